// File: doc/BRIEF.md
# Split-Table Logic Cell

This block is one configurable logic cell. A single 16-entry truth table is addressed by four data inputs. It can act as one 4-input function, or as two 3-input functions that share the three low inputs. Two 2-input taps taken from the same table feed a carry stage, so a chain of cells can carry out arithmetic. Two flip-flops follow the table. Each can capture the combinational result, or it can take part in a two-stage shift path. Both flip-flops also sit on a scan chain.

The configuration is a static parallel word of 22 bits. Bits [15:0] hold the table contents. The bits above them choose the mode, the steering of the third input, the flip-flop sources and whether each output is registered. Each data output can show either the combinational result or the Q of its own flip-flop.

Top module: `split_lut_cell`

## Requirements
- R1: `rst` is active-high and synchronous. It clears both flip-flops at the next rising edge, so `shift_out`, `scan_out` and every registered output read 0 afterwards.
- R2: With `cfg[16]`=1 (wide mode), `cfg[17]`=0 and `cfg[20]`=0, `dout[0]` equals `cfg[din]`. The table index is taken with `din[3]` as its MSB.
- R3: With `cfg[16]`=0 (dual mode) and `cfg[17]`=0, `cfg[20]`=0 and `cfg[21]`=0, `dout[0]` equals `cfg[din[2:0]]` and `dout[1]` equals `cfg[8+din[2:0]]`. `din[3]` has no effect on either output.
- R4: With `cfg[17]`=1, `carry_in` replaces `din[2]` as table input 2. In wide mode, `dout[0]` then equals `cfg[{din[3],carry_in,din[1:0]}]`.
- R5: `carry_out` equals `carry_in` when the propagate tap `cfg[8+din[1:0]]` is 1. Otherwise it equals the generate tap `cfg[din[1:0]]`.
- R6: With `cfg[20]`/`cfg[21]`=1, `cfg[18]`=`cfg[19]`=0 and `scan_en`=0, `dout[0]`/`dout[1]` show the combinational results captured at the last rising edge. These values hold until the next edge.
- R7: With `cfg[18]`=1 flip-flop 0 captures `shift_in`, and with `cfg[19]`=1 flip-flop 1 captures flip-flop 0. `shift_out` is the Q of flip-flop 1, so a bit appears there two edges after it is applied.
- R8: `scan_en`=1 overrides the configuration. Flip-flop 0 takes `scan_in` and flip-flop 1 takes flip-flop 0, and `scan_out` is the Q of flip-flop 1.
- R9: Reset takes priority over `scan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 22 | Static configuration word: table [15:0] and mode bits [21:16] |
| din | input | 4 | Data inputs to the table |
| carry_in | input | 1 | Carry from the previous cell |
| shift_in | input | 1 | Shift-path data into flip-flop 0 |
| scan_en | input | 1 | Selects the scan data for both flip-flops |
| scan_in | input | 1 | Scan data into flip-flop 0 |
| dout | output | 2 | Data outputs, combinational or registered |
| carry_out | output | 1 | Carry to the next cell |
| shift_out | output | 1 | Q of flip-flop 1 on the shift path |
| scan_out | output | 1 | Q of flip-flop 1 on the scan chain |

## Verification
The bench walks every table index in wide and dual mode using asymmetric table patterns. A cell that swapped halves or got the bit order wrong would therefore miscompare, and a dual mode that leaked `din[3]` would show up as a mismatch on the upper indices. It sweeps the carry taps with both values of `carry_in`. This catches swapped generate and propagate terms, and a steering mux that still reads `din[2]`. The registered paths are tested by changing the inputs after the edge, so an output that was not really registered would follow the new input. Long shift and scan sequences, plus a reset applied while scan is enabled, expose wrong stage order, a missing override or a reset of the wrong priority.

// File: rtl/split_lut_pkg.sv
package split_lut_pkg;

    localparam int LUT_K = 4;

    // Mode bits above the table, as offsets from the table width
    localparam int OFS_WIDE    = 0;
    localparam int OFS_STEER   = 1;
    localparam int OFS_F0_SHFT = 2;
    localparam int OFS_F1_CHN  = 3;
    localparam int OFS_OREG0   = 4;
    localparam int OFS_OREG1   = 5;
    localparam int MODE_BITS   = 6;

    typedef enum logic {
        SRC_LOGIC = 1'b0,
        SRC_CHAIN = 1'b1
    } d_src_e;

    typedef struct packed {
        logic q1;
        logic q0;
    } ff_pair_t;

endpackage

// File: rtl/split_lut_table.sv
module split_lut_table #(
    parameter int K = split_lut_pkg::LUT_K
) (
    input  logic [(1<<K)-1:0] tbl,
    input  logic [K-1:0]      idx,
    output logic              full_res,
    output logic [1:0]        half_res,
    output logic [1:0]        quarter_res
);
    localparam int TBL_W = 1 << K;

    assign full_res = tbl[idx];

    // Two sub-tables: lower half (0) and upper half (1)
    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [K-1:0] half_idx;
        logic [K-1:0] quart_idx;
        assign half_idx    = {1'(g), idx[K-2:0]};
        assign quart_idx   = {1'(g), {(K-3){1'b0}}, idx[K-3:0]};
        assign half_res[g]    = tbl[half_idx];
        assign quarter_res[g] = tbl[quart_idx];
    end

endmodule

// File: rtl/split_lut_carry.sv
module split_lut_carry (
    input  logic prop,
    input  logic gen,
    input  logic cin,
    output logic cout
);
    always_comb begin
        cout = gen;
        if (prop) begin
            cout = cin;
        end
    end
endmodule

// File: rtl/split_lut_regs.sv
module split_lut_regs
    import split_lut_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   scan_en,
    input  logic   scan_in,
    input  logic   shift_in,
    input  logic   logic0,
    input  logic   logic1,
    input  d_src_e src0,
    input  d_src_e src1,
    output logic   q0,
    output logic   q1
);
    ff_pair_t state_d;
    ff_pair_t state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = '0;
        end else if (scan_en) begin
            state_d.q0 = scan_in;
            state_d.q1 = state_q.q0;
        end else begin
            state_d.q0 = (src0 == SRC_CHAIN) ? shift_in   : logic0;
            state_d.q1 = (src1 == SRC_CHAIN) ? state_q.q0 : logic1;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q0 = state_q.q0;
    assign q1 = state_q.q1;

endmodule

// File: rtl/split_lut_cell.sv
module split_lut_cell
    import split_lut_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [(1<<K)+MODE_BITS-1:0]    cfg,
    input  logic [K-1:0]                   din,
    input  logic                           carry_in,
    input  logic                           shift_in,
    input  logic                           scan_en,
    input  logic                           scan_in,
    output logic [1:0]                     dout,
    output logic                           carry_out,
    output logic                           shift_out,
    output logic                           scan_out
);
    localparam int TBL_W = 1 << K;

    logic [TBL_W-1:0] tbl;
    logic             mode_wide;
    logic             mode_steer;
    logic [K-1:0]     lut_idx;
    logic             full_res;
    logic [1:0]       half_res;
    logic [1:0]       quarter_res;
    logic [1:0]       logic_out;
    logic [1:0]       oreg;
    logic             ff0_q;
    logic             ff1_q;
    d_src_e           src0;
    d_src_e           src1;

    assign tbl        = cfg[TBL_W-1:0];
    assign mode_wide  = cfg[TBL_W + OFS_WIDE];
    assign mode_steer = cfg[TBL_W + OFS_STEER];
    assign src0       = d_src_e'(cfg[TBL_W + OFS_F0_SHFT]);
    assign src1       = d_src_e'(cfg[TBL_W + OFS_F1_CHN]);
    assign oreg       = {cfg[TBL_W + OFS_OREG1], cfg[TBL_W + OFS_OREG0]};

    // Third table input may be steered from the carry
    always_comb begin
        lut_idx    = din;
        lut_idx[2] = mode_steer ? carry_in : din[2];
    end

    split_lut_table #(.K(K)) u_table (
        .tbl         (tbl),
        .idx         (lut_idx),
        .full_res    (full_res),
        .half_res    (half_res),
        .quarter_res (quarter_res)
    );

    split_lut_carry u_carry (
        .prop (quarter_res[1]),
        .gen  (quarter_res[0]),
        .cin  (carry_in),
        .cout (carry_out)
    );

    assign logic_out[0] = mode_wide ? full_res : half_res[0];
    assign logic_out[1] = half_res[1];

    split_lut_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .shift_in (shift_in),
        .logic0   (logic_out[0]),
        .logic1   (logic_out[1]),
        .src0     (src0),
        .src1     (src1),
        .q0       (ff0_q),
        .q1       (ff1_q)
    );

    assign dout[0]   = oreg[0] ? ff0_q : logic_out[0];
    assign dout[1]   = oreg[1] ? ff1_q : logic_out[1];
    assign shift_out = ff1_q;
    assign scan_out  = ff1_q;

endmodule

// File: rtl/split_lut_checker.sv
module split_lut_checker
    import split_lut_pkg::*;
#(
    parameter int K = LUT_K
) (
    input logic                        clk,
    input logic                        rst,
    input logic [(1<<K)+MODE_BITS-1:0] cfg,
    input logic [K-1:0]                din,
    input logic                        carry_in,
    input logic                        scan_en,
    input logic                        scan_in,
    input logic [1:0]                  dout,
    input logic                        carry_out,
    input logic                        shift_out,
    input logic                        scan_out,
    input logic                        ff0_q
);
    localparam int TBL_W = 1 << K;
    localparam int HALF  = TBL_W / 2;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ff0_q == 1'b0 && shift_out == 1'b0 && scan_out == 1'b0));

    assert_wide_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg[TBL_W + OFS_WIDE] && !cfg[TBL_W + OFS_STEER] && !cfg[TBL_W + OFS_OREG0])
        |-> dout[0] == cfg[din]);

    assert_carry_select_R5: assert property (@(posedge clk) disable iff (rst)
        carry_out == (cfg[HALF + int'(din[K-3:0])] ? carry_in : cfg[int'(din[K-3:0])]));

    assert_shift_stage_R7: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && cfg[TBL_W + OFS_F1_CHN]) |=> shift_out == $past(ff0_q));

    assert_scan_capture_R8: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> ff0_q == $past(scan_in));

    assert_scan_out_R8: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> scan_out == $past(ff0_q));

endmodule

bind split_lut_cell split_lut_checker #(.K(K)) u_split_lut_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .din       (din),
    .carry_in  (carry_in),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .dout      (dout),
    .carry_out (carry_out),
    .shift_out (shift_out),
    .scan_out  (scan_out),
    .ff0_q     (ff0_q)
);

// File: tb/test_split_lut_cell.sv
`timescale 1ns/1ps
module test_split_lut_cell;

    logic        clk = 1'b0;
    logic        rst;
    logic [21:0] cfg;
    logic [3:0]  din;
    logic        carry_in;
    logic        shift_in;
    logic        scan_en;
    logic        scan_in;
    logic [1:0]  dout;
    logic        carry_out;
    logic        shift_out;
    logic        scan_out;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    split_lut_cell i_split_lut_cell (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .din       (din),
        .carry_in  (carry_in),
        .shift_in  (shift_in),
        .scan_en   (scan_en),
        .scan_in   (scan_in),
        .dout      (dout),
        .carry_out (carry_out),
        .shift_out (shift_out),
        .scan_out  (scan_out)
    );

    function automatic logic [21:0] mkcfg(input logic [15:0] t, input logic wide,
        input logic steer, input logic f0s, input logic f1c, input logic r0, input logic r1);
        return {r1, r0, f1c, f0s, steer, wide, t};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg = mkcfg(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        din = 4'hF; carry_in = 1'b1; shift_in = 1'b1;
        scan_en = 1'b0; scan_in = 1'b1;
        tick();
        check("R1 dout0", dout[0], 1'b0);
        check("R1 dout1", dout[1], 1'b0);
        check("R1 shift_out", shift_out, 1'b0);
        check("R1 scan_out", scan_out, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_wide();
        logic [15:0] t = 16'hA5C3;
        cfg = mkcfg(t, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            din = 4'(i);
            #1;
            check("R2 wide", dout[0], t[i]);
        end
    endtask

    task automatic t_dual();
        logic [15:0] t = 16'h6E29;
        cfg = mkcfg(t, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            din = 4'(i);
            #1;
            check("R3 low half", dout[0], t[i % 8]);
            check("R3 high half", dout[1], t[8 + (i % 8)]);
        end
    endtask

    task automatic t_steer();
        logic [15:0] t = 16'h3C96;
        cfg = mkcfg(t, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 32; i++) begin
            din = 4'(i);
            carry_in = i[4];
            #1;
            check("R4 steer", dout[0], t[{din[3], carry_in, din[1:0]}]);
        end
        carry_in = 1'b0;
    endtask

    task automatic t_carry();
        logic [15:0] t = 16'h0A06;
        cfg = mkcfg(t, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [1:0] lo = 2'(i);
            din = {i[3], 1'b0, lo};
            carry_in = i[2];
            #1;
            check("R5 carry", carry_out, t[8 + lo] ? carry_in : t[lo]);
        end
        carry_in = 1'b0;
    endtask

    task automatic t_registered();
        logic [15:0] t = 16'hB471;
        logic [3:0]  d;
        cfg = mkcfg(t, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            d = 4'((i * 7 + 3) % 16);
            din = d;
            tick();
            check("R6 reg out0", dout[0], t[d]);
            check("R6 reg out1", dout[1], t[8 + d[2:0]]);
            din = ~d;
            #1;
            check("R6 hold out0", dout[0], t[d]);
            check("R6 hold out1", dout[1], t[8 + d[2:0]]);
        end
    endtask

    task automatic t_shift();
        logic [11:0] pat = 12'b1011_0011_1010;
        logic m0 = 1'b0;
        logic m1 = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0;
        cfg = mkcfg(16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 12; i++) begin
            shift_in = pat[i];
            tick();
            m1 = m0; m0 = pat[i];
            check("R7 shift_out", shift_out, m1);
            check("R7 stage0", dout[0], m0);
        end
        shift_in = 1'b0;
    endtask

    task automatic t_scan();
        logic [11:0] pat = 12'b0110_1110_0101;
        logic m0 = 1'b0;
        logic m1 = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0;
        // Logic sources selected and table all ones: scan must win
        cfg = mkcfg(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        shift_in = 1'b1;
        scan_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            scan_in = pat[i];
            tick();
            m1 = m0; m0 = pat[i];
            check("R8 scan_out", scan_out, m1);
            check("R8 scan stage0", dout[0], m0);
        end
    endtask

    task automatic t_reset_priority();
        cfg = mkcfg(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        scan_en = 1'b1; scan_in = 1'b1;
        tick();
        tick();
        rst = 1'b1;
        tick();
        check("R9 ff0", dout[0], 1'b0);
        check("R9 scan_out", scan_out, 1'b0);
        rst = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    endtask

    initial begin
        #400000;
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg = '0; din = '0; carry_in = 1'b0;
        shift_in = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide();
        t_dual();
        t_steer();
        t_carry();
        t_registered();
        t_shift();
        t_scan();
        t_reset_priority();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule